// File: doc/BRIEF.md
# Dual-Pixel Data-Enable Raster Timing Generator

This block paces a 1920x1080 progressive raster for a panel that takes two pixels on every clock and is framed by a single data-enable line. There are no horizontal or vertical sync pulses. A horizontal and a vertical position counter run freely. While both counters are inside the active window, the block asks its pixel-pair source for data through a ready signal. It registers the accepted pair onto an even-pixel bus and an odd-pixel bus and raises DE in the same cycle. Every active line starts with an even pixel, so the first pixel of a frame always leaves on the even bus.

The active window is fixed by parameters. The horizontal and vertical blanking lengths are picked at each frame boundary from two inputs. A blanking input of zero selects a built-in preset, and a frame-rate select chooses between the 60 Hz preset and the 50 Hz preset. Any non-zero request is clamped into the legal range. Horizontal blanking is given in pixel periods and rounded down to whole clocks. Strobes mark the first active cycle of a frame and of each line.

Top module: `pair_raster_gen`

## Requirements
- R1: DE is high for exactly ACT_PIX/2 consecutive clocks on each active line and for ACT_LINES lines per frame. Active lines come first in a frame and active clocks come first in a line.
- R2: A line lasts ACT_PIX/2 + B/2 clocks and a frame lasts ACT_LINES + V lines, where B is the effective horizontal blank in pixel periods and V is the effective vertical blank in lines. Both totals repeat exactly from frame to frame.
- R3: Whenever DE is low, both pixel buses are zero.
- R4: src_ready is high exactly in the clocks whose following cycle carries DE high. A pair accepted on a clock edge appears on the buses after that edge: the even input on even_rgb and the odd input on odd_rgb. Each bus is laid out with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: If src_valid is low in an active clock, DE still rises and both buses carry zero for that cycle. The raster timing does not change.
- R6: sof is high for one cycle together with the first DE cycle of a frame. sol is high together with the first DE cycle of every active line. The first output cycle after reset is such a cycle.
- R7: The blanking inputs and rate_sel are sampled only at the frame boundary and during reset. A change made during a frame takes effect from the next frame.
- R8: A non-zero horizontal request is clamped to HBLK_MIN..HBLK_MAX pixel periods, and a non-zero vertical request is clamped to VBLK_MIN..VBLK_MAX lines.
- R9: A blanking input of zero selects the preset given by rate_sel: 0 selects H60_BLANK/V60_BLANK and 1 selects H50_BLANK/V50_BLANK.
- R10: The horizontal blank is rounded down to an even number of pixel periods, so an odd request loses its lowest bit.
- R11: While rst_n is low at a clock edge, DE, sof, sol and both buses are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 1 | Preset choice: 0 for 60 Hz, 1 for 50 Hz |
| hblank_cfg | input | CFG_HW | Horizontal blank request in pixel periods; 0 selects the preset |
| vblank_cfg | input | CFG_VW | Vertical blank request in lines; 0 selects the preset |
| src_valid | input | 1 | The source holds a valid pixel pair |
| src_ready | output | 1 | The block takes the pair on this clock edge |
| src_even | input | 24 | Even (first) pixel of the pair, RGB |
| src_odd | input | 24 | Odd (second) pixel of the pair, RGB |
| de | output | 1 | Data enable |
| even_rgb | output | 24 | Even pixel output bus |
| odd_rgb | output | 24 | Odd pixel output bus |
| sof | output | 1 | First active cycle of a frame |
| sol | output | 1 | First active cycle of a line |

## Verification
The bound checker watches, on every cycle, the local rules that tie the outputs together. These are the zero buses outside DE, the one-cycle link between ready and DE, the strobes landing on DE edges, and the exact length of every DE run. Frame and line totals depend on configuration, and so do the clamping, the presets, the rounding and the moment a new setting takes effect. Only the bench's scenarios can show these, by measuring whole frames after each change. The same holds for the ordering and content of the pixel data and for the underrun behaviour.

// File: rtl/prg_pkg.sv
// Package prg_pkg
// Holds helpers shared by the raster generator modules.
// Assumes all quantities passed in fit in 32-bit unsigned integers.
package prg_pkg;

    // Limit a value to the closed range lo..hi.
    function automatic int unsigned clamp_u(input int unsigned v,
                                            input int unsigned lo,
                                            input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/prg_blank_cfg.sv
// Module prg_blank_cfg
// Turns raw blanking requests into effective horizontal blank clocks and
// vertical blank lines, and holds them for a whole frame.
// A zero request picks the preset chosen by rate_sel. A non-zero request
// is clamped to the legal range. Horizontal blanking in pixel periods is
// halved to clocks, which drops the lowest bit.
// Assumes load is high on the last cycle of a frame; values are also
// captured while reset is applied.
module prg_blank_cfg #(
    parameter int unsigned CFG_HW    = 10,
    parameter int unsigned CFG_VW    = 7,
    parameter int unsigned HBLK_MIN  = 180,
    parameter int unsigned HBLK_MAX  = 380,
    parameter int unsigned VBLK_MIN  = 35,
    parameter int unsigned VBLK_MAX  = 59,
    parameter int unsigned H60_BLANK = 280,
    parameter int unsigned V60_BLANK = 45,
    parameter int unsigned H50_BLANK = 380,
    parameter int unsigned V50_BLANK = 59,
    parameter int unsigned HC_W      = 8,
    parameter int unsigned VL_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rate_sel,
    input  logic [CFG_HW-1:0] hblank_cfg,
    input  logic [CFG_VW-1:0] vblank_cfg,
    output logic [HC_W-1:0]   hblk_clk,
    output logic [VL_W-1:0]   vblk_lines
);

    int unsigned     h_req, v_req, h_pix, v_lin;
    logic [HC_W-1:0] h_nxt;
    logic [VL_W-1:0] v_nxt;

    // Choose the preset or the request, clamp it and convert to clocks.
    always_comb begin
        h_req = (hblank_cfg == '0) ? (rate_sel ? H50_BLANK : H60_BLANK)
                                   : 32'(hblank_cfg);
        v_req = (vblank_cfg == '0) ? (rate_sel ? V50_BLANK : V60_BLANK)
                                   : 32'(vblank_cfg);
        h_pix = prg_pkg::clamp_u(h_req, HBLK_MIN, HBLK_MAX);
        v_lin = prg_pkg::clamp_u(v_req, VBLK_MIN, VBLK_MAX);
        h_nxt = HC_W'(h_pix >> 1);
        v_nxt = VL_W'(v_lin);
    end

    // Capture the effective blanking during reset and at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            hblk_clk   <= h_nxt;
            vblk_lines <= v_nxt;
        end
    end

endmodule

// File: rtl/prg_raster_cnt.sv
// Module prg_raster_cnt
// Free-running horizontal (clock) and vertical (line) position counters.
// Each line and each frame starts with its active part.
// Reports the active window, line and frame starts, and the last cycle of
// a frame.
// Assumes the blanking inputs stay stable within a frame.
module prg_raster_cnt #(
    parameter int unsigned ACT_CLK   = 960,
    parameter int unsigned ACT_LINES = 1080,
    parameter int unsigned HC_W      = 8,
    parameter int unsigned VL_W      = 6,
    parameter int unsigned HT_W      = 11,
    parameter int unsigned VT_W      = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HC_W-1:0] hblk_clk,
    input  logic [VL_W-1:0] vblk_lines,
    output logic            active,
    output logic            line_first,
    output logic            frame_first,
    output logic            frame_last
);

    logic [HT_W-1:0] h_q, line_len;
    logic [VT_W-1:0] v_q, frame_len;
    logic            h_end, v_end;

    // Derive the totals and the end-of-line and end-of-frame conditions.
    always_comb begin
        line_len    = HT_W'(ACT_CLK) + HT_W'(hblk_clk);
        frame_len   = VT_W'(ACT_LINES) + VT_W'(vblk_lines);
        h_end       = (h_q == line_len - HT_W'(1));
        v_end       = (v_q == frame_len - VT_W'(1));
        frame_last  = h_end && v_end;
        active      = (h_q < HT_W'(ACT_CLK)) && (v_q < VT_W'(ACT_LINES));
        line_first  = (h_q == '0) && (v_q < VT_W'(ACT_LINES));
        frame_first = (h_q == '0) && (v_q == '0);
    end

    // Advance the clock position, and the line position at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (h_end) begin
            h_q <= '0;
            v_q <= v_end ? '0 : v_q + VT_W'(1);
        end else begin
            h_q <= h_q + HT_W'(1);
        end
    end

endmodule

// File: rtl/prg_pixel_out.sv
// Module prg_pixel_out
// Output register stage. It registers DE, the two strobes and one pixel
// per lane. A lane carries the accepted pixel only when the cycle is
// active and the source is valid, and zero otherwise.
// Assumes lane 0 is the even pixel.
module prg_pixel_out #(
    parameter int unsigned LANES = 2,
    parameter int unsigned PIX_W = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        active,
    input  logic                        line_first,
    input  logic                        frame_first,
    input  logic                        src_valid,
    input  logic [LANES-1:0][PIX_W-1:0] lane_in,
    output logic [LANES-1:0][PIX_W-1:0] lane_out,
    output logic                        de,
    output logic                        sof,
    output logic                        sol
);

    logic take;
    assign take = active && src_valid;

    // Register the framing signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de  <= 1'b0;
            sof <= 1'b0;
            sol <= 1'b0;
        end else begin
            de  <= active;
            sof <= frame_first;
            sol <= line_first;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Register one pixel lane, forcing zero outside accepted cycles.
        always_ff @(posedge clk) begin
            if (!rst_n || !take) lane_out[i] <= '0;
            else                 lane_out[i] <= lane_in[i];
        end
    end

endmodule

// File: rtl/pair_raster_gen.sv
// Module pair_raster_gen
// Top of the dual-pixel data-enable raster generator. It ties together the
// blanking selection, the position counters and the output stage.
// Assumes a synchronous active-low reset and a source that keeps a pair
// on its inputs while src_valid is high.
module pair_raster_gen #(
    parameter int unsigned ACT_PIX   = 1920,
    parameter int unsigned ACT_LINES = 1080,
    parameter int unsigned CH_W      = 8,
    parameter int unsigned CFG_HW    = 10,
    parameter int unsigned CFG_VW    = 7,
    parameter int unsigned HBLK_MIN  = 180,
    parameter int unsigned HBLK_MAX  = 380,
    parameter int unsigned VBLK_MIN  = 35,
    parameter int unsigned VBLK_MAX  = 59,
    parameter int unsigned H60_BLANK = 280,
    parameter int unsigned V60_BLANK = 45,
    parameter int unsigned H50_BLANK = 380,
    parameter int unsigned V50_BLANK = 59
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rate_sel,
    input  logic [CFG_HW-1:0]   hblank_cfg,
    input  logic [CFG_VW-1:0]   vblank_cfg,
    input  logic                src_valid,
    output logic                src_ready,
    input  logic [3*CH_W-1:0]   src_even,
    input  logic [3*CH_W-1:0]   src_odd,
    output logic                de,
    output logic [3*CH_W-1:0]   even_rgb,
    output logic [3*CH_W-1:0]   odd_rgb,
    output logic                sof,
    output logic                sol
);

    localparam int unsigned LANES   = 2;
    localparam int unsigned PIX_W   = 3 * CH_W;
    localparam int unsigned ACT_CLK = ACT_PIX / LANES;
    localparam int unsigned HC_W    = $clog2(HBLK_MAX / LANES + 1);
    localparam int unsigned VL_W    = $clog2(VBLK_MAX + 1);
    localparam int unsigned HT_W    = $clog2(ACT_CLK + HBLK_MAX / LANES + 1);
    localparam int unsigned VT_W    = $clog2(ACT_LINES + VBLK_MAX + 1);

    logic                        active, line_first, frame_first, frame_last;
    logic [HC_W-1:0]             hblk_clk;
    logic [VL_W-1:0]             vblk_lines;
    logic [LANES-1:0][PIX_W-1:0] lane_in, lane_out;

    prg_blank_cfg #(
        .CFG_HW(CFG_HW), .CFG_VW(CFG_VW),
        .HBLK_MIN(HBLK_MIN), .HBLK_MAX(HBLK_MAX),
        .VBLK_MIN(VBLK_MIN), .VBLK_MAX(VBLK_MAX),
        .H60_BLANK(H60_BLANK), .V60_BLANK(V60_BLANK),
        .H50_BLANK(H50_BLANK), .V50_BLANK(V50_BLANK),
        .HC_W(HC_W), .VL_W(VL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(frame_last), .rate_sel(rate_sel),
        .hblank_cfg(hblank_cfg), .vblank_cfg(vblank_cfg),
        .hblk_clk(hblk_clk), .vblk_lines(vblk_lines)
    );

    prg_raster_cnt #(
        .ACT_CLK(ACT_CLK), .ACT_LINES(ACT_LINES),
        .HC_W(HC_W), .VL_W(VL_W), .HT_W(HT_W), .VT_W(VT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .hblk_clk(hblk_clk), .vblk_lines(vblk_lines),
        .active(active), .line_first(line_first),
        .frame_first(frame_first), .frame_last(frame_last)
    );

    assign lane_in   = {src_odd, src_even};
    assign even_rgb  = lane_out[0];
    assign odd_rgb   = lane_out[1];
    assign src_ready = active && rst_n;

    prg_pixel_out #(.LANES(LANES), .PIX_W(PIX_W)) u_out (
        .clk(clk), .rst_n(rst_n), .active(active),
        .line_first(line_first), .frame_first(frame_first),
        .src_valid(src_valid), .lane_in(lane_in), .lane_out(lane_out),
        .de(de), .sof(sof), .sol(sol)
    );

endmodule

// File: rtl/prg_checker.sv
// Module prg_checker
// Cycle-by-cycle rules on the outputs of pair_raster_gen. It is attached
// by bind. A local counter measures the length of each DE run.
module prg_checker #(
    parameter int unsigned ACT_CLK = 960,
    parameter int unsigned PIX_W   = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             de,
    input logic             sof,
    input logic             sol,
    input logic             src_ready,
    input logic [PIX_W-1:0] even_rgb,
    input logic [PIX_W-1:0] odd_rgb
);

    logic [31:0] run_q;

    // Count consecutive DE-high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !de) run_q <= '0;
        else               run_q <= run_q + 32'd1;
    end

    a_r3_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (even_rgb == '0 && odd_rgb == '0));

    a_r4_ready_then_de: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |=> de);

    a_r4_de_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> $past(src_ready));

    a_r6_sof_on_de: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (de && sol));

    a_r6_sol_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> sol);

    a_r6_sol_on_de: assert property (@(posedge clk) disable iff (!rst_n)
        sol |-> de);

    a_r1_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> (run_q == 32'(ACT_CLK)));

    a_r1_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 32'(ACT_CLK));

endmodule

bind pair_raster_gen prg_checker #(.ACT_CLK(ACT_PIX / 2), .PIX_W(3 * CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .de(de), .sof(sof), .sol(sol),
    .src_ready(src_ready), .even_rgb(even_rgb), .odd_rgb(odd_rgb)
);

// File: tb/tb_pair_raster_gen.sv
// Directed bench for pair_raster_gen with a small raster.
module tb_pair_raster_gen;

    localparam int ACT_PIX = 16, ACT_LINES = 4, ACT_CLK = ACT_PIX / 2;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0, rst_n = 1'b0, rate_sel = 1'b0;
    logic [9:0]  hblank_cfg = '0;
    logic [6:0]  vblank_cfg = '0;
    logic        src_valid = 1'b1, src_ready;
    logic [23:0] src_even = '0, src_odd = '0, even_rgb, odd_rgb;
    logic        de, sof, sol;

    int  vec = 0, bad = 0;
    bit  want_valid = 1'b1, done = 1'b0;

    pair_raster_gen #(
        .ACT_PIX(ACT_PIX), .ACT_LINES(ACT_LINES),
        .HBLK_MIN(4), .HBLK_MAX(12), .VBLK_MIN(2), .VBLK_MAX(5),
        .H60_BLANK(6), .V60_BLANK(3), .H50_BLANK(10), .V50_BLANK(4)
    ) dut (.*);

    always #(CLK_NS / 2) clk = ~clk;

    function automatic logic [23:0] pat_e(int k);
        return {8'(k), ~8'(k), 8'(k) ^ 8'h5A};
    endfunction
    function automatic logic [23:0] pat_o(int k);
        return {8'(k + 128), 8'(3 * k), ~8'(k + 7)};
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Source driver and per-cycle data checks (R3, R4, R5).
    initial begin
        int  k = 0;
        bit  prev_valid = 1'b1, rdy_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(de == rdy_prev, "R4", "de after ready", de, rdy_prev);
                if (de && prev_valid) begin
                    chk(even_rgb == pat_e(k), "R4", "even bus", even_rgb, pat_e(k));
                    chk(odd_rgb == pat_o(k), "R4", "odd bus", odd_rgb, pat_o(k));
                    k++;
                end else if (de) begin
                    chk(even_rgb == 0 && odd_rgb == 0, "R5", "underrun bus",
                        even_rgb | odd_rgb, 0);
                end else begin
                    chk(even_rgb == 0 && odd_rgb == 0, "R3", "blank bus",
                        even_rgb | odd_rgb, 0);
                end
            end
            rdy_prev   = src_ready;
            src_even   = pat_e(k);
            src_odd    = pat_o(k);
            src_valid  = want_valid;
            prev_valid = want_valid;
        end
    end

    task automatic sync_sof();
        do @(negedge clk); while (!sof);
    endtask

    // Measure one frame starting at a negedge where sof is high (R1, R2).
    task automatic check_frame(int hclk, int vbl, string rq);
        int ftot = 0, de_tot = 0, lines = 0, run = 0, last_sol = -1;
        int bad_run = 0, bad_per = 0;
        do begin
            if (de) begin de_tot++; run++; end
            else begin
                if (run != 0) begin lines++; if (run != ACT_CLK) bad_run++; end
                run = 0;
            end
            if (sol) begin
                if (last_sol >= 0 && ftot - last_sol != ACT_CLK + hclk) bad_per++;
                last_sol = ftot;
            end
            ftot++;
            @(negedge clk);
        end while (!sof);
        chk(ftot == (ACT_CLK + hclk) * (ACT_LINES + vbl), rq, "frame clocks",
            ftot, (ACT_CLK + hclk) * (ACT_LINES + vbl));
        chk(de_tot == ACT_CLK * ACT_LINES, "R1", "DE clocks", de_tot, ACT_CLK * ACT_LINES);
        chk(lines == ACT_LINES, "R1", "DE lines", lines, ACT_LINES);
        chk(bad_run == 0, "R1", "bad DE runs", bad_run, 0);
        chk(bad_per == 0, "R2", "bad line periods", bad_per, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!de && !sof && !sol && even_rgb == 0 && odd_rgb == 0, "R11",
            "reset outputs", {de, sof, sol}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(de && sof && sol, "R6", "first cycle strobes", {de, sof, sol}, 7);
    endtask

    // Zero requests give the 60 Hz preset, and the totals repeat (R9, R2).
    task automatic t_preset60();
        sync_sof();
        check_frame(3, 3, "R9");
        check_frame(3, 3, "R2");
    endtask

    // rate_sel changed mid-frame applies only from the next frame (R7, R9).
    task automatic t_preset50();
        sync_sof();
        rate_sel = 1'b1;
        check_frame(3, 3, "R7");
        check_frame(5, 4, "R9");
    endtask

    // Explicit in-range requests (R2, R7).
    task automatic t_explicit();
        sync_sof();
        hblank_cfg = 10'd8; vblank_cfg = 7'd2;
        check_frame(5, 4, "R7");
        check_frame(4, 2, "R2");
    endtask

    // Requests above and below the limits are clamped (R8).
    task automatic t_clamp();
        sync_sof();
        hblank_cfg = 10'd1000; vblank_cfg = 7'd100;
        check_frame(4, 2, "R7");
        hblank_cfg = 10'd1; vblank_cfg = 7'd1;
        check_frame(6, 5, "R8");
        check_frame(2, 2, "R8");
    endtask

    // An odd horizontal request is rounded down (R10).
    task automatic t_odd();
        sync_sof();
        hblank_cfg = 10'd9; vblank_cfg = 7'd3;
        check_frame(2, 2, "R7");
        check_frame(4, 3, "R10");
    endtask

    // Source withholds data for a frame; timing is unchanged (R5).
    task automatic t_underrun();
        sync_sof();
        hblank_cfg = 10'd0; vblank_cfg = 7'd0; rate_sel = 1'b0;
        check_frame(4, 3, "R7");
        want_valid = 1'b0;
        check_frame(3, 3, "R5");
        want_valid = 1'b1;
        check_frame(3, 3, "R5");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        vec++; bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_preset60();
        t_preset50();
        t_explicit();
        t_clamp();
        t_odd();
        t_underrun();
        finish_run();
    end

endmodule